// File: doc/BRIEF.md
# Capacitive Key Touch Qualifier

This block turns raw per-burst acquisition counts from a small set of capacitive sense keys into clean, debounced touch states. Each key holds a calibrated reference level. The signed delta is the reference minus the latest count, so a positive delta means a rise in load, which is the direction a finger pushes. A key is declared touched once the delta crosses a threshold for enough bursts in a row. It is released only after a separate run of non-detect bursts, with a small hysteresis band between the two levels.

Between touches the reference follows slow environmental change. It moves slowly when the count falls and faster when the count rises. A key that stays touched past a selectable limit, or whose count stays well above its reference for long enough, is recalibrated on its own, and the other keys are left alone. A millisecond tick input paces every timed behaviour. The per-key deltas are brought out so that neighbouring suppression logic can compare signal strengths.

Top module: `touch_qual`

## Requirements
- R1: For an idle key, a burst counts as a detect only when its delta (reference minus count) is at least 10. A delta of 9 never starts a touch.
- R2: When `fast_mode`=0, touch starts on the 6th consecutive detect burst. When `fast_mode`=1, it starts on the 2nd. A non-detect burst restarts the count from zero.
- R3: For a touched key, a burst with delta of at least 8 still counts as a detect. The touch ends on the 6th consecutive burst with delta of 7 or less, in either mode.
- R4: For an idle key with zero integrator count, a positive delta lowers the reference by 1 after every DRIFT_UP_MS ticks. A negative delta above -6 raises the reference by 1 after every DRIFT_DN_MS ticks.
- R5: Drift is frozen while a key is touched or while its integrator is counting.
- R6: When an idle key's delta stays at -6 or below for NEG_RECAL_MS ticks, the reference is reloaded from the last count, giving a delta of 0. Drift is held during that wait.
- R7: `on_sel` selects the maximum on-duration: 0 selects ON_SHORT_MS ticks, 1 selects ON_LONG_MS ticks, and 2 or 3 disables the limit. When the limit expires, only that key is released and its reference is reloaded from its last count. Other keys keep their state.
- R8: After reset, `cal_done` stays 0 until CAL_MS ticks have passed and at least one burst has arrived. While `cal_done` is 0, every burst loads each reference and no key is touched. Once `cal_done` is 1, it stays 1 until reset.
- R9: A key whose `key_unused` bit is 1 reports touch 0 and delta 0 whatever its counts are.
- R10: In reset, all touch bits are 0, `cal_done` is 0 and all deltas are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_valid | input | 1 | One-cycle strobe: new counts are present |
| burst_counts | input | NKEYS*CW | Count of key i at bits [i*CW +: CW] |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| fast_mode | input | 1 | 1 selects the short attack run |
| on_sel | input | 2 | Maximum on-duration select (see R7) |
| key_unused | input | NKEYS | Bit i set marks key i as unused |
| touch | output | NKEYS | Qualified touch state per key |
| key_delta | output | NKEYS*(CW+1) | Signed delta of key i at bits [i*(CW+1) +: CW+1] |
| cal_done | output | 1 | Startup calibration complete |

## Verification
The bench drives deltas that sit just under and exactly at the attack threshold, so an off-by-one threshold shows up. It uses detect streaks broken by a single quiet burst, which separate a true consecutive counter from a cumulative one, and attack runs in both modes against a fixed release run. Release is tried with bursts on each side of the hysteresis level. Tick runs stop one tick short of each drift, negative-recalibration and on-duration limit and then one tick past it, and one test has two keys touched at once to show that expiry on one key leaves the other alone.

// File: rtl/touch_qual_pkg.sv
// Package: shared constants and mode encodings for the touch qualifier.
// Assumes the on-duration select is a 2-bit field driven by static mode pins.
package touch_qual_pkg;
    // On-duration select codes
    localparam logic [1:0] ONSEL_SHORT = 2'd0;
    localparam logic [1:0] ONSEL_LONG  = 2'd1;
    localparam logic [1:0] ONSEL_OFF   = 2'd2;

    // Integrator run lengths
    localparam int ATTACK_RUN  = 6;
    localparam int FAST_RUN    = 2;
    localparam int RELEASE_RUN = 6;

    // Delta levels in counts
    localparam int TOUCH_LEVEL = 10;
    localparam int HYST_BAND   = 2;
    localparam int NEG_LEVEL   = 6;
endpackage

// File: rtl/touch_cal_ctl.sv
// Startup calibration gate: raises done once CAL_MS ticks have elapsed
// and at least one burst has been seen. Assumes ms_tick is a single-cycle pulse.
module touch_cal_ctl #(
    parameter int CAL_MS = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst,
    input  logic tick,
    output logic done
);
    localparam int CTW = $clog2(CAL_MS + 1);

    logic [CTW-1:0] tmr_q;
    logic           seen_q;
    logic           tdone;

    assign tdone = (tmr_q == CTW'(CAL_MS));
    assign done  = tdone & seen_q;

    // Count startup ticks and note the first burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (tick && !tdone) tmr_q <= tmr_q + 1'b1;
            if (burst)          seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/touch_key_chan.sv
// One key channel: reference tracking, hysteretic detect, attack/release
// integrator, asymmetric drift, negative-excursion recalibration and
// on-duration timeout. Assumes ON_LONG_MS is the largest timed limit
// (TW is sized from it) and that ticks are spaced by at least one cycle.
// A tick that lands on a burst cycle is held and serviced on the next free cycle.
module touch_key_chan #(
    parameter int CW        = 8,
    parameter int TW        = 16,
    parameter int THR       = 10,
    parameter int HYS       = 2,
    parameter int NEG_TH    = 6,
    parameter int ATT_N     = 6,
    parameter int FAST_N    = 2,
    parameter int REL_N     = 6,
    parameter int UP_MS     = 2000,
    parameter int DN_MS     = 500,
    parameter int NEG_MS    = 2000,
    parameter int ON_SHORT  = 10000,
    parameter int ON_LONG   = 60000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_active,
    input  logic                 burst,
    input  logic [CW-1:0]        cnt_in,
    input  logic                 tick,
    input  logic                 fast,
    input  logic [1:0]           on_sel,
    input  logic                 unused,
    output logic                 touched,
    output logic signed [CW:0]   delta
);
    localparam int DW = CW + 1;
    localparam int IN_MAX = (ATT_N > REL_N) ? ATT_N : REL_N;
    localparam int IW = $clog2(IN_MAX + 1);
    localparam logic signed [DW-1:0] LVL_ON  = DW'(THR);
    localparam logic signed [DW-1:0] LVL_OFF = DW'(THR - HYS);
    localparam logic signed [DW-1:0] LVL_NEG = DW'(-NEG_TH);

    logic [CW-1:0]          base_q, cur_q;
    logic                   touched_q, pend_q;
    logic [IW-1:0]          integ_q, need;
    logic [TW-1:0]          up_q, dn_q, neg_q, on_q, on_lim;
    logic signed [DW-1:0]   d_now, d_in;
    logic                   det, flip, on_en, neg_zone, tick_go;

    // Delta arithmetic and qualification decisions
    always_comb begin
        d_now    = $signed({1'b0, base_q}) - $signed({1'b0, cur_q});
        d_in     = $signed({1'b0, base_q}) - $signed({1'b0, cnt_in});
        det      = touched_q ? (d_in >= LVL_OFF) : (d_in >= LVL_ON);
        flip     = touched_q ? !det : det;
        need     = touched_q ? IW'(REL_N) : (fast ? IW'(FAST_N) : IW'(ATT_N));
        on_en    = !on_sel[1];
        on_lim   = on_sel[0] ? TW'(ON_LONG - 1) : TW'(ON_SHORT - 1);
        neg_zone = (d_now <= LVL_NEG);
        tick_go  = (tick | pend_q) & !burst;
    end

    // Per-key state: calibration, integrator, timers and reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            cur_q     <= '0;
            touched_q <= 1'b0;
            pend_q    <= 1'b0;
            integ_q   <= '0;
            up_q      <= '0;
            dn_q      <= '0;
            neg_q     <= '0;
            on_q      <= '0;
        end else if (unused || cal_active) begin
            touched_q <= 1'b0;
            pend_q    <= 1'b0;
            integ_q   <= '0;
            up_q      <= '0;
            dn_q      <= '0;
            neg_q     <= '0;
            on_q      <= '0;
            if (burst) begin
                base_q <= cnt_in;
                cur_q  <= cnt_in;
            end
        end else begin
            pend_q <= burst ? (pend_q | tick) : 1'b0;
            if (burst) begin
                cur_q <= cnt_in;
                if (flip) begin
                    if (integ_q == need - 1'b1) begin
                        touched_q <= !touched_q;
                        integ_q   <= '0;
                        on_q      <= '0;
                    end else begin
                        integ_q <= integ_q + 1'b1;
                    end
                end else begin
                    integ_q <= '0;
                end
            end else if (tick_go) begin
                if (touched_q) begin
                    up_q  <= '0;
                    dn_q  <= '0;
                    neg_q <= '0;
                    if (!on_en) begin
                        on_q <= '0;
                    end else if (on_q == on_lim) begin
                        base_q    <= cur_q;
                        touched_q <= 1'b0;
                        integ_q   <= '0;
                        on_q      <= '0;
                    end else begin
                        on_q <= on_q + 1'b1;
                    end
                end else if (integ_q != '0) begin
                    up_q  <= '0;
                    dn_q  <= '0;
                    neg_q <= '0;
                end else if (neg_zone) begin
                    up_q <= '0;
                    dn_q <= '0;
                    if (neg_q == TW'(NEG_MS - 1)) begin
                        base_q <= cur_q;
                        neg_q  <= '0;
                    end else begin
                        neg_q <= neg_q + 1'b1;
                    end
                end else begin
                    neg_q <= '0;
                    if (d_now > 0) begin
                        dn_q <= '0;
                        if (up_q == TW'(UP_MS - 1)) begin
                            base_q <= base_q - 1'b1;
                            up_q   <= '0;
                        end else begin
                            up_q <= up_q + 1'b1;
                        end
                    end else if (d_now < 0) begin
                        up_q <= '0;
                        if (dn_q == TW'(DN_MS - 1)) begin
                            base_q <= base_q + 1'b1;
                            dn_q   <= '0;
                        end else begin
                            dn_q <= dn_q + 1'b1;
                        end
                    end else begin
                        up_q <= '0;
                        dn_q <= '0;
                    end
                end
            end
        end
    end

    assign touched = touched_q;
    assign delta   = unused ? '0 : d_now;
endmodule

// File: rtl/touch_qual.sv
// Top: calibration gate plus one qualification channel per key.
// Assumes counts are sampled only on burst_valid and that modes are quasi-static.
module touch_qual
    import touch_qual_pkg::*;
#(
    parameter int NKEYS        = 2,
    parameter int CW           = 8,
    parameter int CAL_MS       = 450,
    parameter int DRIFT_UP_MS  = 2000,
    parameter int DRIFT_DN_MS  = 500,
    parameter int NEG_RECAL_MS = 2000,
    parameter int ON_SHORT_MS  = 10000,
    parameter int ON_LONG_MS   = 60000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    burst_valid,
    input  logic [NKEYS*CW-1:0]     burst_counts,
    input  logic                    ms_tick,
    input  logic                    fast_mode,
    input  logic [1:0]              on_sel,
    input  logic [NKEYS-1:0]        key_unused,
    output logic [NKEYS-1:0]        touch,
    output logic [NKEYS*(CW+1)-1:0] key_delta,
    output logic                    cal_done
);
    localparam int DW = CW + 1;
    localparam int TW = $clog2(ON_LONG_MS + 1);

    touch_cal_ctl #(.CAL_MS(CAL_MS)) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .burst (burst_valid),
        .tick  (ms_tick),
        .done  (cal_done)
    );

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        touch_key_chan #(
            .CW(CW), .TW(TW), .THR(TOUCH_LEVEL), .HYS(HYST_BAND), .NEG_TH(NEG_LEVEL),
            .ATT_N(ATTACK_RUN), .FAST_N(FAST_RUN), .REL_N(RELEASE_RUN),
            .UP_MS(DRIFT_UP_MS), .DN_MS(DRIFT_DN_MS), .NEG_MS(NEG_RECAL_MS),
            .ON_SHORT(ON_SHORT_MS), .ON_LONG(ON_LONG_MS)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cal_active (!cal_done),
            .burst      (burst_valid),
            .cnt_in     (burst_counts[k*CW +: CW]),
            .tick       (ms_tick),
            .fast       (fast_mode),
            .on_sel     (on_sel),
            .unused     (key_unused[k]),
            .touched    (touch[k]),
            .delta      (key_delta[k*DW +: DW])
        );
    end
endmodule

// File: rtl/touch_qual_chk.sv
// Checker: temporal properties on the qualifier ports, bound to touch_qual.
module touch_qual_chk #(
    parameter int NKEYS = 2,
    parameter int CW    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    burst_valid,
    input logic [NKEYS-1:0]        key_unused,
    input logic [NKEYS-1:0]        touch,
    input logic [NKEYS*(CW+1)-1:0] key_delta,
    input logic                    cal_done
);
    localparam int DW = CW + 1;

    // R8: no key touched before calibration completes
    a_r8_no_touch_uncal: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> (touch == '0));

    // R8: calibration done never drops outside reset
    a_r8_cal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);

    for (genvar k = 0; k < NKEYS; k++) begin : g_chk
        // R1: a touch starts only right after a burst
        a_r1_rise_on_burst: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(touch[k]) |-> $past(burst_valid));

        // R1: a new touch shows a delta at or above the threshold
        a_r1_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(touch[k]) |-> ($signed(key_delta[k*DW +: DW]) >= 10));

        // R9: an unused key stays untouched
        a_r9_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (key_unused[k] && $past(key_unused[k])) |-> !touch[k]);
    end
endmodule

bind touch_qual touch_qual_chk #(.NKEYS(NKEYS), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_valid (burst_valid),
    .key_unused  (key_unused),
    .touch       (touch),
    .key_delta   (key_delta),
    .cal_done    (cal_done)
);

// File: tb/touch_qual_bench.sv
// Scoreboard bench: driver tasks queue expected touch/delta items; a
// monitor pops and compares them after each stimulus step.
module touch_qual_bench;
    localparam int NK = 2;
    localparam int CW = 8;
    localparam int DW = CW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              burst_valid = 1'b0;
    logic [NK*CW-1:0]  burst_counts = '0;
    logic              ms_tick = 1'b0;
    logic              fast_mode = 1'b0;
    logic [1:0]        on_sel = 2'd2;
    logic [NK-1:0]     key_unused = '0;
    logic [NK-1:0]     touch;
    logic [NK*DW-1:0]  key_delta;
    logic              cal_done;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [1:0] t;
        int         d0;
        int         d1;
        string      tag;
    } exp_t;

    exp_t  sb[$];
    event  ev_cmp;

    always #2.5 clk = ~clk;

    touch_qual #(
        .NKEYS(NK), .CW(CW), .CAL_MS(4), .DRIFT_UP_MS(20), .DRIFT_DN_MS(5),
        .NEG_RECAL_MS(20), .ON_SHORT_MS(40), .ON_LONG_MS(100)
    ) u_touch_qual (
        .clk(clk), .rst_n(rst_n), .burst_valid(burst_valid),
        .burst_counts(burst_counts), .ms_tick(ms_tick), .fast_mode(fast_mode),
        .on_sel(on_sel), .key_unused(key_unused), .touch(touch),
        .key_delta(key_delta), .cal_done(cal_done)
    );

    // Monitor: compare outputs with the oldest queued expectation
    always @(ev_cmp) begin
        while (sb.size() > 0) begin
            exp_t e;
            int   a0, a1;
            e  = sb.pop_front();
            a0 = $signed(key_delta[0 +: DW]);
            a1 = $signed(key_delta[DW +: DW]);
            total++;
            if (touch !== e.t || a0 != e.d0 || a1 != e.d1) begin
                bad++;
                $display("FAIL %s: touch=%b d0=%0d d1=%0d expected touch=%b d0=%0d d1=%0d",
                         e.tag, touch, a0, a1, e.t, e.d0, e.d1);
            end
        end
    end

    task automatic expect_now(input logic [1:0] t, input int d0, input int d1, input string tag);
        exp_t e;
        e.t = t; e.d0 = d0; e.d1 = d1; e.tag = tag;
        sb.push_back(e);
        ->ev_cmp;
        #0.1;
    endtask

    task automatic burst(input int c0, input int c1, input logic [1:0] t,
                         input int d0, input int d1, input string tag);
        @(negedge clk);
        burst_counts = {CW'(c1), CW'(c0)};
        burst_valid  = 1'b1;
        @(negedge clk);
        burst_valid  = 1'b0;
        expect_now(t, d0, d1, tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cal_done=%b expected %b", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver: directed stimulus per requirement
    initial begin
        repeat (5) @(negedge clk);
        expect_now(2'b00, 0, 0, "R10 reset");
        check_bit(cal_done, 1'b0, "R10 reset");
        rst_n = 1'b1;

        // R8: calibration loads references, gate waits for ticks
        burst(100, 100, 2'b00, 0, 0, "R8 cal burst");
        check_bit(cal_done, 1'b0, "R8 before ticks");
        ticks(4);
        check_bit(cal_done, 1'b1, "R8 after ticks");

        // R1: delta 9 never touches
        for (int i = 0; i < 8; i++) burst(91, 100, 2'b00, 9, 0, "R1 below level");

        // R2: broken streak restarts the attack count
        for (int i = 0; i < 3; i++) burst(90, 100, 2'b00, 10, 0, "R2 streak");
        burst(100, 100, 2'b00, 0, 0, "R2 break");
        for (int i = 0; i < 5; i++) burst(90, 100, 2'b00, 10, 0, "R2 restart");
        burst(90, 100, 2'b01, 10, 0, "R2 sixth burst");

        // R3: hysteresis keeps the touch, then six quiet bursts release
        burst(92, 100, 2'b01, 8, 0, "R3 hysteresis hold");
        for (int i = 0; i < 5; i++) burst(93, 100, 2'b01, 7, 0, "R3 release run");
        burst(93, 100, 2'b00, 7, 0, "R3 released");

        // R2 fast attack, R3 release length unchanged
        fast_mode = 1'b1;
        burst(90, 100, 2'b00, 10, 0, "R2 fast first");
        burst(90, 100, 2'b01, 10, 0, "R2 fast second");
        for (int i = 0; i < 5; i++) burst(100, 100, 2'b01, 0, 0, "R3 fast release run");
        burst(100, 100, 2'b00, 0, 0, "R3 fast released");
        fast_mode = 1'b0;

        // R4: drift in both directions
        burst(95, 100, 2'b00, 5, 0, "R4 up setup");
        ticks(19);
        expect_now(2'b00, 5, 0, "R4 up not yet");
        ticks(1);
        expect_now(2'b00, 4, 0, "R4 up step");
        burst(103, 100, 2'b00, -4, 0, "R4 dn setup");
        ticks(5);
        expect_now(2'b00, -3, 0, "R4 dn step");

        // R5: drift frozen while touched (on-duration disabled)
        for (int i = 0; i < 5; i++) burst(90, 100, 2'b00, 10, 0, "R5 attack");
        burst(90, 100, 2'b01, 10, 0, "R5 touched");
        ticks(30);
        expect_now(2'b01, 10, 0, "R5 drift frozen");

        // R7: on-duration expiry on key 0 only
        on_sel = 2'd0;
        ticks(20);
        for (int i = 0; i < 5; i++) burst(90, 90, 2'b01, 10, 10, "R7 key1 attack");
        burst(90, 90, 2'b11, 10, 10, "R7 both touched");
        ticks(19);
        expect_now(2'b11, 10, 10, "R7 before limit");
        ticks(1);
        expect_now(2'b10, 0, 10, "R7 key0 expired");
        on_sel = 2'd2;

        // R6: negative excursion recalibration
        for (int i = 0; i < 5; i++) burst(100, 100, 2'b10, -10, 0, "R6 key1 release run");
        burst(100, 100, 2'b00, -10, 0, "R6 key1 released");
        ticks(19);
        expect_now(2'b00, -10, 0, "R6 before limit");
        ticks(1);
        expect_now(2'b00, 0, 0, "R6 recalibrated");

        // R9: unused key stays quiet
        key_unused = 2'b10;
        for (int i = 0; i < 6; i++) burst(100, 50, 2'b00, 0, 0, "R9 unused");
        check_bit(cal_done, 1'b1, "R8 sticky");

        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule